// File: doc/BRIEF.md
# SPI Register Access Master

This block carries out one register read or write on an external peripheral over a four-wire SPI link. A request names a 6-bit register, a 15-bit sub-address (zero means none) and a data length. The block builds a one-, two- or three-byte header from these fields. It then shifts the data bytes out for a write, or clocks dummy bytes out and collects the reply for a read. Chip select stays low for the whole exchange. Read bytes come back packed little-endian in a 40-bit result word.

The host raises `start` for one cycle while `busy` is low. The result is valid in the cycle where `done` pulses. The block also screens the peripheral's interrupt line, so the host never sees an interrupt while a transfer owns the bus. An interrupt that arrives during that window is handed on once chip select is released. The SCLK half period is `HALF_DIV` system clocks.

Top module: `spi_reg_master`

## Requirements
- R1: After reset `csN`=1, `sclk`=0, `busy`=0, `done`=0, `rData`=0, and `irqOut` follows `irqIn`.
- R2: The first header byte is {bit7 = writeEn, bit6 = (subAddr != 0), bits5:0 = regId}. When subAddr is zero it is the only header byte.
- R3: A subAddr from 1 to 0x7F adds exactly one header byte equal to subAddr, with bit 7 clear.
- R4: A subAddr above 0x7F adds two header bytes. The first is {1, subAddr[6:0]}, with bit 7 as the extension flag. The second is subAddr[14:7].
- R5: On a write, the data bytes follow the header least significant byte first: byte j is wData[8j+7:8j]. The byte count is `len` when `len` is 1, 2, 4 or 5, and 1 for any other value.
- R6: On a read, each data byte sent is 0x00. The j-th byte returned goes to rData[8j+7:8j], and bytes at or above the length read as zero. After a write, rData is zero.
- R7: The link runs in SPI mode 0. SCLK is low whenever chip select is high. MOSI holds steady while SCLK is high. Bits go MSB first and are sampled on the rising SCLK edge.
- R8: Each transaction drives `csN` low exactly once. During that low period the link carries exactly 8 × (header + data bytes) SCLK pulses.
- R9: `irqOut` is 0 whenever `csN` is 0. If `irqIn` was high at any point while `csN` was low, `irqOut` is 1 in the first cycle after `csN` returns high.
- R10: `busy` is high from the cycle after `start` is accepted until the idle gap ends. `done` is a one-cycle pulse in the first cycle in which `csN` is high again.
- R11: A `start` while `busy` is high is ignored. `csN` stays high for at least 2 × HALF_DIV cycles between transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only while idle |
| regId | input | 6 | Register identifier |
| subAddr | input | 15 | Sub-address, zero for none |
| writeEn | input | 1 | 1 for a write, 0 for a read |
| len | input | 3 | Data byte count (1, 2, 4 or 5) |
| wData | input | 40 | Write data, little-endian |
| busy | output | 1 | Transaction or idle gap in progress |
| done | output | 1 | One-cycle completion pulse |
| rData | output | 40 | Read result, valid with done |
| sclk | output | 1 | SPI clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| irqIn | input | 1 | Interrupt from the peripheral |
| irqOut | output | 1 | Gated interrupt to the host |

## Verification
Two functions can fall in the same cycle: completion and interrupt release. Chip select rising, `done`, the result latch and the hand-off of a held interrupt all happen at one clock edge. The bench raises `irqIn` for two cycles in the middle of a transfer and drops it well before the end. It then expects `irqOut` high exactly in the `done` cycle and low in the next, with the captured byte stream still correct. A second coincidence is a `start` arriving mid-transfer or during the idle gap. The bench checks that this start creates no new chip-select period and that the wire stream still carries the first request.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int RegIdW     = 6;
  localparam int SubW       = 15;
  localparam int LenW       = 3;
  localparam int MaxData    = 5;
  localparam int DataW      = 8 * MaxData;
  localparam int HdrMax     = 3;
  localparam int HdrW       = 8 * HdrMax;
  localparam int StreamW    = 8 * (HdrMax + MaxData);
  localparam int BitCntW    = $clog2(StreamW);

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic finish;
  } ctlStrobeT;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH,
    PH_TAIL,
    PH_GAP
  } phaseT;

  function automatic logic [LenW-1:0] normLen(input logic [LenW-1:0] l);
    case (l)
      3'd1, 3'd2, 3'd4, 3'd5: normLen = l;
      default:                normLen = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/spi_reg_hdr.sv
module spi_reg_hdr
  import spi_reg_pkg::*;
(
  input  logic [RegIdW-1:0]  regId,
  input  logic [SubW-1:0]    subAddr,
  input  logic               writeEn,
  input  logic [LenW-1:0]    dataLen,
  input  logic [DataW-1:0]   wData,
  output logic [StreamW-1:0] txStream,
  output logic [BitCntW-1:0] lastBitIdx
);
  logic             hasSub;
  logic             extSub;
  logic [1:0]       hdrLen;
  logic [HdrW-1:0]  hdrVec;
  logic [DataW-1:0] dataVec;

  always_comb begin
    hasSub = |subAddr;
    extSub = |subAddr[SubW-1:7];
    hdrVec = '0;
    hdrVec[HdrW-1 -: 8] = {writeEn, hasSub, regId};
    if (!hasSub) begin
      hdrLen = 2'd1;
    end else if (!extSub) begin
      hdrLen = 2'd2;
      hdrVec[HdrW-9 -: 8] = subAddr[7:0];
    end else begin
      hdrLen = 2'd3;
      hdrVec[HdrW-9 -: 8] = {1'b1, subAddr[6:0]};
      hdrVec[7:0]         = subAddr[SubW-1:7];
    end
    // first data byte on the wire is the least significant one
    for (int j = 0; j < MaxData; j++) begin
      dataVec[DataW-1-8*j -: 8] = writeEn ? wData[8*j +: 8] : 8'h00;
    end
    txStream = {hdrVec, {(StreamW-HdrW){1'b0}}}
             | ({dataVec, {(StreamW-DataW){1'b0}}} >> (8 * hdrLen));
    lastBitIdx = BitCntW'(8 * (int'(hdrLen) + int'(dataLen)) - 1);
  end
endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobeT          strobe,
  input  logic [RegIdW-1:0]  regId,
  input  logic [SubW-1:0]    subAddr,
  input  logic               writeEn,
  input  logic [LenW-1:0]    len,
  input  logic [DataW-1:0]   wData,
  input  logic               miso,
  output logic               mosi,
  output logic               lastBit,
  output logic [DataW-1:0]   rData
);
  logic [StreamW-1:0] txVec;
  logic [StreamW-1:0] rxVec;
  logic [BitCntW-1:0] bitCnt;
  logic [LenW-1:0]    dataLenQ;
  logic               writeQ;
  logic [LenW-1:0]    dataLenD;
  logic [StreamW-1:0] hdrStream;
  logic [BitCntW-1:0] lastIdx;
  logic [DataW-1:0]   rdAsm;

  assign dataLenD = normLen(len);

  spi_reg_hdr u_hdr (
    .regId      (regId),
    .subAddr    (subAddr),
    .writeEn    (writeEn),
    .dataLen    (dataLenD),
    .wData      (wData),
    .txStream   (hdrStream),
    .lastBitIdx (lastIdx)
  );

  // the last data byte received sits in the low byte of rxVec
  always_comb begin
    rdAsm = '0;
    for (int j = 0; j < MaxData; j++) begin
      if (j < int'(dataLenQ)) begin
        rdAsm[8*j +: 8] = 8'(rxVec >> (8 * (int'(dataLenQ) - 1 - j)));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txVec    <= '0;
      rxVec    <= '0;
      bitCnt   <= '0;
      dataLenQ <= 3'd1;
      writeQ   <= 1'b0;
      rData    <= '0;
    end else begin
      if (strobe.load) begin
        txVec    <= hdrStream;
        rxVec    <= '0;
        bitCnt   <= lastIdx;
        dataLenQ <= dataLenD;
        writeQ   <= writeEn;
      end
      if (strobe.sample) begin
        rxVec <= {rxVec[StreamW-2:0], miso};
      end
      if (strobe.shift) begin
        txVec  <= {txVec[StreamW-2:0], 1'b0};
        bitCnt <= bitCnt - 1'b1;
      end
      if (strobe.finish) begin
        rData <= writeQ ? '0 : rdAsm;
      end
    end
  end

  assign mosi    = txVec[StreamW-1];
  assign lastBit = (bitCnt == '0);

  // R8: the control never asks for a further bit once the count is spent
  p_shift_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> bitCnt != '0);
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      lastBit,
  input  logic      irqIn,
  output ctlStrobeT strobe,
  output logic      busy,
  output logic      done,
  output logic      csN,
  output logic      sclk,
  output logic      irqOut
);
  localparam int DivW = $clog2(2 * HALF_DIV + 1);

  phaseT           phase;
  logic [DivW-1:0] divCnt;
  logic            halfTick;
  logic            fullTick;
  logic            csActive;
  logic            irqPend;

  assign halfTick = (divCnt == DivW'(HALF_DIV - 1));
  assign fullTick = (divCnt == DivW'(2 * HALF_DIV - 1));
  assign csActive = (phase == PH_LOW) || (phase == PH_HIGH) || (phase == PH_TAIL);

  always_comb begin
    strobe        = '0;
    strobe.load   = (phase == PH_IDLE) && start;
    strobe.sample = (phase == PH_LOW)  && halfTick;
    strobe.shift  = (phase == PH_HIGH) && halfTick && !lastBit;
    strobe.finish = (phase == PH_TAIL) && halfTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      divCnt  <= '0;
      done    <= 1'b0;
      irqPend <= 1'b0;
    end else begin
      done    <= 1'b0;
      irqPend <= csActive ? (irqPend | irqIn) : 1'b0;
      case (phase)
        PH_IDLE: begin
          divCnt <= '0;
          if (start) phase <= PH_LOW;
        end
        PH_LOW: begin
          if (halfTick) begin
            divCnt <= '0;
            phase  <= PH_HIGH;
          end else divCnt <= divCnt + 1'b1;
        end
        PH_HIGH: begin
          if (halfTick) begin
            divCnt <= '0;
            phase  <= lastBit ? PH_TAIL : PH_LOW;
          end else divCnt <= divCnt + 1'b1;
        end
        PH_TAIL: begin
          if (halfTick) begin
            divCnt <= '0;
            phase  <= PH_GAP;
            done   <= 1'b1;
          end else divCnt <= divCnt + 1'b1;
        end
        PH_GAP: begin
          if (fullTick) begin
            divCnt <= '0;
            phase  <= PH_IDLE;
          end else divCnt <= divCnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (phase != PH_IDLE);
  assign csN    = !csActive;
  assign sclk   = (phase == PH_HIGH);
  assign irqOut = !csActive && (irqIn || irqPend);

  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.sample, strobe.shift, strobe.finish}));
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !irqOut);
  p_done_edge_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && $past(!csN)));
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !$fell(csN));
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [5:0]  regId,
  input  logic [14:0] subAddr,
  input  logic        writeEn,
  input  logic [2:0]  len,
  input  logic [39:0] wData,
  output logic        busy,
  output logic        done,
  output logic [39:0] rData,
  output logic        sclk,
  output logic        csN,
  output logic        mosi,
  input  logic        miso,
  input  logic        irqIn,
  output logic        irqOut
);
  ctlStrobeT strobe;
  logic      lastBit;

  spi_reg_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .lastBit (lastBit),
    .irqIn   (irqIn),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done),
    .csN     (csN),
    .sclk    (sclk),
    .irqOut  (irqOut)
  );

  spi_reg_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regId   (regId),
    .subAddr (subAddr),
    .writeEn (writeEn),
    .len     (len),
    .wData   (wData),
    .miso    (miso),
    .mosi    (mosi),
    .lastBit (lastBit),
    .rData   (rData)
  );
endmodule

// File: tb/sim_spi_reg_master.sv
module sim_spi_reg_master;
  localparam int ClkPeriod = 10;
  localparam int HalfDiv   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  regId = '0;
  logic [14:0] subAddr = '0;
  logic        writeEn = 1'b0;
  logic [2:0]  len = '0;
  logic [39:0] wData = '0;
  logic        miso = 1'b0;
  logic        irqIn = 1'b0;
  logic        busy, done, sclk, csN, mosi, irqOut;
  logic [39:0] rData;

  spi_reg_master #(.HALF_DIV(HalfDiv)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .regId(regId), .subAddr(subAddr),
    .writeEn(writeEn), .len(len), .wData(wData), .busy(busy), .done(done),
    .rData(rData), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .irqIn(irqIn), .irqOut(irqOut)
  );

  always #(ClkPeriod/2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  // peripheral model
  logic [63:0] slavePat = '0;
  logic [63:0] capBits = '0;
  logic        mosiAtRise = 1'b0;
  int capCnt = 0, misoIdx = 0, csFalls = 0, fallsAtLaunch = 0;

  always @(negedge csN) begin
    capBits = '0; capCnt = 0; misoIdx = 0; miso = slavePat[63]; csFalls++;
  end
  always @(posedge sclk) begin
    capBits = {capBits[62:0], mosi}; capCnt++; mosiAtRise = mosi;
  end
  always @(negedge sclk) begin
    misoIdx++;
    if (misoIdx < 64) miso = slavePat[63 - misoIdx];
  end

  // line monitors
  int sclkLeak = 0, modeErr = 0, irqLeak = 0, highRun = 0, minGap = 1000;
  bit seenLow = 0;
  always @(negedge clk) if (rstN) begin
    if (csN && sclk) sclkLeak++;
    if (sclk && mosi !== mosiAtRise) modeErr++;
    if (!csN && irqOut) irqLeak++;
    if (csN) highRun++;
    else begin
      if (seenLow && highRun > 0 && highRun < minGap) minGap = highRun;
      seenLow = 1; highRun = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic int nLen(input logic [2:0] l);
    return (l == 3'd1 || l == 3'd2 || l == 3'd4 || l == 3'd5) ? int'(l) : 1;
  endfunction
  function automatic int hLen(input logic [14:0] s);
    return (s == 0) ? 1 : ((s <= 15'h7F) ? 2 : 3);
  endfunction
  function automatic logic [63:0] expHdr(input logic [5:0] r, input logic [14:0] s, input logic wr);
    logic [63:0] v;
    v = 64'(wr) * 128 + 64'(s != 0) * 64 + 64'(r);
    if (hLen(s) == 2) v = (v << 8) | 64'(s[7:0]);
    if (hLen(s) == 3) begin
      v = (v << 8) | (64'h80 + 64'(s % 128));
      v = (v << 8) | 64'(s / 128);
    end
    return v;
  endfunction
  function automatic logic [63:0] expData(input logic wr, input logic [2:0] l, input logic [39:0] wd);
    logic [63:0] v = '0;
    for (int j = 0; j < nLen(l); j++) v = (v << 8) | (wr ? 64'((wd >> (8*j)) & 40'hFF) : 64'h0);
    return v;
  endfunction
  function automatic logic [39:0] expRead(input logic [14:0] s, input logic [2:0] l, input logic [63:0] pat);
    logic [39:0] v = '0;
    for (int j = 0; j < nLen(l); j++)
      v = v | (40'((pat >> (56 - 8*(hLen(s) + j))) & 64'hFF) << (8*j));
    return v;
  endfunction

  task automatic launch(input logic [5:0] r, input logic [14:0] s, input logic wr,
                        input logic [2:0] l, input logic [39:0] wd, input logic [63:0] pat);
    @(negedge clk);
    while (busy) @(negedge clk);
    slavePat = pat; regId = r; subAddr = s; writeEn = wr; len = l; wData = wd;
    fallsAtLaunch = csFalls;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10", "busy after start", 64'(busy), 64'h1);
  endtask

  task automatic awaitDone();
    int guard = 0;
    while (done !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
    chk(done === 1'b1, "R10", "done reached", 64'(done), 64'h1);
  endtask

  // called at the negedge where done is high
  task automatic checkTxn(input logic [5:0] r, input logic [14:0] s, input logic wr,
                          input logic [2:0] l, input logic [39:0] wd, input logic [63:0] pat);
    int h, d;
    logic [63:0] hdrAct, datAct, dMask;
    string hTag;
    h = hLen(s); d = nLen(l);
    dMask = (64'h1 << (8*d)) - 1;
    hdrAct = capBits >> (8*d);
    datAct = capBits & dMask;
    hTag = (h == 1) ? "R2" : ((h == 2) ? "R3" : "R4");
    chk(capCnt == 8*(h+d), "R8", "bit count", 64'(capCnt), 64'(8*(h+d)));
    chk(csFalls - fallsAtLaunch == 1, "R8", "cs low periods", 64'(csFalls - fallsAtLaunch), 64'h1);
    chk(hdrAct == expHdr(r, s, wr), hTag, "header bytes", hdrAct, expHdr(r, s, wr));
    chk(datAct == expData(wr, l, wd), wr ? "R5" : "R6", "data bytes", datAct, expData(wr, l, wd));
    chk(csN === 1'b1, "R10", "cs high with done", 64'(csN), 64'h1);
    if (wr) chk(rData == 40'h0, "R6", "rData after write", 64'(rData), 64'h0);
    else    chk(rData == expRead(s, l, pat), "R6", "read result", 64'(rData), 64'(expRead(s, l, pat)));
    @(negedge clk);
    chk(done === 1'b0, "R10", "done single pulse", 64'(done), 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    logic [14:0] subs [6];
    subs[0] = 15'h0000; subs[1] = 15'h0001; subs[2] = 15'h007F;
    subs[3] = 15'h0080; subs[4] = 15'h1234; subs[5] = 15'h7FFF;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(csN === 1'b1 && sclk === 1'b0, "R1", "lines in reset", {62'h0, csN, sclk}, 64'h2);
    chk(busy === 1'b0 && done === 1'b0, "R1", "handshake in reset", {62'h0, busy, done}, 64'h0);
    chk(rData === 40'h0, "R1", "rData in reset", 64'(rData), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    irqIn = 1'b1;
    @(negedge clk);
    chk(irqOut === 1'b1, "R1", "idle irq pass-through", 64'(irqOut), 64'h1);
    irqIn = 1'b0;
    @(negedge clk);
    chk(irqOut === 1'b0, "R9", "idle irq low", 64'(irqOut), 64'h0);

    // sweep of sub-address forms, lengths and directions
    for (int si = 0; si < 6; si++) begin
      for (int l = 0; l < 8; l++) begin
        for (int w = 0; w < 2; w++) begin
          logic [5:0] r; logic [39:0] wd; logic [63:0] pat;
          r   = 6'((si * 13 + l * 7 + w * 29) % 64);
          wd  = 40'hC3_5A_96_E1_0F ^ 40'(si * 40'h1_0101_0101 + l * 40'h37 + w);
          pat = 64'h9E37_79B9_7F4A_7C15 ^ (64'(si * 8 + l) << (w * 5));
          launch(r, subs[si], w[0], 3'(l), wd, pat);
          awaitDone();
          checkTxn(r, subs[si], w[0], 3'(l), wd, pat);
        end
      end
    end

    // R9: interrupt raised mid-transfer and dropped before release
    launch(6'h11, 15'h0042, 1'b0, 3'd4, 40'h0, 64'h0123_4567_89AB_CDEF);
    repeat (20) @(negedge clk);
    irqIn = 1'b1;
    repeat (2) @(negedge clk);
    irqIn = 1'b0;
    awaitDone();
    chk(irqOut === 1'b1, "R9", "held irq at release", 64'(irqOut), 64'h1);
    checkTxn(6'h11, 15'h0042, 1'b0, 3'd4, 40'h0, 64'h0123_4567_89AB_CDEF);
    chk(irqOut === 1'b0, "R9", "held irq cleared", 64'(irqOut), 64'h0);

    // R11: start while busy is ignored
    launch(6'h05, 15'h0000, 1'b1, 3'd2, 40'h00_0000_BEEF, 64'h0);
    repeat (10) @(negedge clk);
    regId = 6'h3A; subAddr = 15'h4000; writeEn = 1'b0; len = 3'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    awaitDone();
    checkTxn(6'h05, 15'h0000, 1'b1, 3'd2, 40'h00_0000_BEEF, 64'h0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2 * HalfDiv + 2) @(negedge clk);
    chk(csN === 1'b1 && busy === 1'b0, "R11", "start in gap ignored", {62'h0, csN, busy}, 64'h2);

    chk(sclkLeak == 0, "R7", "sclk high with cs high", 64'(sclkLeak), 64'h0);
    chk(modeErr == 0, "R7", "mosi moved while sclk high", 64'(modeErr), 64'h0);
    chk(irqLeak == 0, "R9", "irq seen during transfer", 64'(irqLeak), 64'h0);
    chk(minGap >= 2 * HalfDiv, "R11", "cs high gap", 64'(minGap), 64'(2 * HalfDiv));
    summary();
  end
endmodule